// File: doc/BRIEF.md
# Split Read Tag Tracker

This block keeps the books for a requester that issues split read requests on a parallel, PCI-X style bus. When the requester places a read, it takes a free 5-bit tag from the tracker. The tracker records three things against that tag: the 16-bit identity of the requester, the 12-bit byte count and a destination handle. The requester then leaves the bus instead of retrying. The target answers later with one completion per request, returned only when all of the requested data is ready. That completion carries a tag, a requester identity and a byte count.

Each completion is looked up by its tag and checked against the stored identity. An accepted completion retires its tag and reports the destination that was recorded with the request. Its returned byte count is compared with the stored one. A completion that cannot be matched is flagged and dropped, and it leaves the table as it was. When every tag is in use, the allocate port stalls new requests.

Top module: `split_tag_tracker`

## Requirements
- R1: Synchronous reset holds and leaves no tag outstanding: `busy_count` is 0, `req_ready` is 1, `req_tag` is 0, and `done_valid`, `err_unexp` and `err_len` are 0.
- R2: While at least one tag is free, `req_ready` is 1 and `req_tag` shows the lowest-numbered free tag. A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. From that edge on, the tag is outstanding with the request's identity, byte count and destination.
- R3: With all 32 tags outstanding, `req_ready` is 0. A request offered then is not taken, and `busy_count` stays at 32.
- R4: A completion is accepted when its tag is outstanding and its requester identity equals the stored one. In the cycle after, `done_valid` is 1 for one cycle, `done_tag` carries the tag and `done_dest` the stored destination, and the tag is free again.
- R5: A completion whose tag is not outstanding raises `err_unexp` for one cycle in the next cycle. It does not raise `done_valid` and frees no tag.
- R6: A completion whose tag is outstanding but whose requester identity differs raises `err_unexp` in the next cycle. The entry stays outstanding and can still be completed with the right identity. The identity is {bus[15:8], device[7:3], function[2:0]}.
- R7: An accepted completion whose byte count differs from the stored one raises `err_len` in the same cycle as its `done_valid`. Its tag is still released.
- R8: A tag is offered again only after its completion has been accepted. Once it is free, it is offered in order of tag number.
- R9: A request and a completion in the same cycle both take effect. The tag freed by that completion is offered from the next cycle on, not in the same cycle. A completion for the tag being allocated in that same cycle counts as not outstanding.
- R10: `busy_count` always equals the number of outstanding tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A new split read request is offered |
| req_rid | input | 16 | Requester identity of the request |
| req_bytes | input | 12 | Byte count of the request |
| req_dest | input | 8 | Destination handle stored with the request |
| req_ready | output | 1 | A free tag is available |
| req_tag | output | 5 | Tag granted to the offered request |
| cpl_valid | input | 1 | A split completion is present |
| cpl_rid | input | 16 | Requester identity carried by the completion |
| cpl_tag | input | 5 | Tag carried by the completion |
| cpl_bytes | input | 12 | Byte count carried by the completion |
| done_valid | output | 1 | One-cycle pulse: completion accepted and tag retired |
| done_tag | output | 5 | Tag retired |
| done_dest | output | 8 | Destination recorded for the retired tag |
| err_unexp | output | 1 | One-cycle pulse: completion dropped (tag idle or identity wrong) |
| err_len | output | 1 | One-cycle pulse: accepted completion had a wrong byte count |
| busy_count | output | 6 | Number of outstanding tags |

## Verification
Allocation and retirement can fall in the same clock cycle. The bench provokes this by offering a request and a completion together, both at a full table and at a partly filled one. It also sends a completion for the very tag that is being granted in that cycle. A behavioural model of the tag set judges each such cycle on every clock. That model has its own busy flags and lowest-free search. It expects both effects at once, and it expects the freed tag to be offered only in the next cycle. It also expects the completion of the tag being granted to be reported as unexpected.

// File: rtl/tag_tracker_pkg.sv
// Shared widths, types and helpers for the split read tag tracker.
// Assumes: one requester identity layout, bus/device/function packed high to low.
package tag_tracker_pkg;
    localparam int TAG_W    = 5;
    localparam int NUM_TAGS = 1 << TAG_W;
    localparam int CNT_W    = TAG_W + 1;
    localparam int BUS_W    = 8;
    localparam int DEV_W    = 5;
    localparam int FN_W     = 3;
    localparam int RID_W    = BUS_W + DEV_W + FN_W;
    localparam int BC_W     = 12;
    localparam int DEST_W   = 8;

    typedef logic [TAG_W-1:0]    tag_t;
    typedef logic [RID_W-1:0]    rid_t;
    typedef logic [BC_W-1:0]     bc_t;
    typedef logic [DEST_W-1:0]   dest_t;
    typedef logic [NUM_TAGS-1:0] mask_t;

    typedef struct packed {
        rid_t  rid;
        bc_t   bytes;
        dest_t dest;
    } entry_t;

    // Packs bus, device and function numbers into a requester identity.
    function automatic rid_t make_rid(input logic [BUS_W-1:0] bus_n,
                                      input logic [DEV_W-1:0] dev_n,
                                      input logic [FN_W-1:0]  fn_n);
        return {bus_n, dev_n, fn_n};
    endfunction
endpackage

// File: rtl/tag_alloc.sv
// Picks the lowest-numbered free tag from the busy mask and flags a full table.
// Assumes: purely combinational; the caller decides whether the grant is used.
module tag_alloc
    import tag_tracker_pkg::*;
(
    input  mask_t busy,
    output tag_t  free_tag,
    output logic  full
);
    // Priority search: scanning downward leaves the lowest free index last.
    always_comb begin
        free_tag = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_tag = tag_t'(i);
            end
        end
    end

    // Table is full when no busy bit is clear.
    always_comb begin
        full = &busy;
    end
endmodule

// File: rtl/tag_store.sv
// Holds one entry per tag plus its outstanding flag.
// Assumes: a write and a clear never target the same tag in one cycle
// (the writer only picks free tags, the clearer only busy ones).
module tag_store
    import tag_tracker_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  tag_t   wr_tag,
    input  entry_t wr_entry,
    input  logic   clr_en,
    input  tag_t   clr_tag,
    input  tag_t   rd_tag,
    output mask_t  busy,
    output entry_t rd_entry
);
    entry_t mem [NUM_TAGS];

    // One outstanding flag per tag, set on allocation and cleared on retirement.
    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[g] <= 1'b0;
            end else if (wr_en && (wr_tag == tag_t'(g))) begin
                busy[g] <= 1'b1;
            end else if (clr_en && (clr_tag == tag_t'(g))) begin
                busy[g] <= 1'b0;
            end
        end
    end

    // Entry payload is written on allocation; no reset needed since flags gate it.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_tag] <= wr_entry;
        end
    end

    // Asynchronous lookup for the completion checker.
    always_comb begin
        rd_entry = mem[rd_tag];
    end
endmodule

// File: rtl/cpl_check.sv
// Judges one incoming completion against the stored entry of its tag.
// Assumes: rd_entry is the entry addressed by cpl_tag in the same cycle.
module cpl_check
    import tag_tracker_pkg::*;
(
    input  logic   cpl_valid,
    input  rid_t   cpl_rid,
    input  tag_t   cpl_tag,
    input  bc_t    cpl_bytes,
    input  mask_t  busy,
    input  entry_t rd_entry,
    output logic   accept,
    output logic   reject,
    output logic   len_bad
);
    logic live;
    logic rid_ok;

    // Tag must be outstanding and carry the same requester identity.
    always_comb begin
        live    = busy[cpl_tag];
        rid_ok  = (rd_entry.rid == cpl_rid);
        accept  = cpl_valid && live && rid_ok;
        reject  = cpl_valid && !(live && rid_ok);
        len_bad = accept && (rd_entry.bytes != cpl_bytes);
    end
endmodule

// File: rtl/split_tag_tracker.sv
// Top of the split read tag tracker: grants tags, records requests, matches
// completions, retires tags and reports per-completion status one cycle later.
// Assumes: at most one request and one completion per cycle; status outputs
// are single-cycle pulses registered at the edge that updates the table.
module split_tag_tracker
    import tag_tracker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [BC_W-1:0]   req_bytes,
    input  logic [DEST_W-1:0] req_dest,
    output logic              req_ready,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              cpl_valid,
    input  logic [RID_W-1:0]  cpl_rid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [BC_W-1:0]   cpl_bytes,
    output logic              done_valid,
    output logic [TAG_W-1:0]  done_tag,
    output logic [DEST_W-1:0] done_dest,
    output logic              err_unexp,
    output logic              err_len,
    output logic [CNT_W-1:0]  busy_count
);
    mask_t  busy_mask;
    tag_t   free_tag;
    logic   full;
    logic   alloc_fire;
    entry_t new_entry;
    entry_t look_entry;
    logic   accept;
    logic   reject;
    logic   len_bad;

    tag_alloc u_alloc (
        .busy     (busy_mask),
        .free_tag (free_tag),
        .full     (full)
    );

    // Request side: grant when a tag is free and pack the entry to store.
    always_comb begin
        req_ready       = !full;
        req_tag         = free_tag;
        alloc_fire      = req_valid && !full;
        new_entry.rid   = req_rid;
        new_entry.bytes = req_bytes;
        new_entry.dest  = req_dest;
    end

    tag_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (alloc_fire),
        .wr_tag   (free_tag),
        .wr_entry (new_entry),
        .clr_en   (accept),
        .clr_tag  (cpl_tag),
        .rd_tag   (cpl_tag),
        .busy     (busy_mask),
        .rd_entry (look_entry)
    );

    cpl_check u_check (
        .cpl_valid (cpl_valid),
        .cpl_rid   (cpl_rid),
        .cpl_tag   (cpl_tag),
        .cpl_bytes (cpl_bytes),
        .busy      (busy_mask),
        .rd_entry  (look_entry),
        .accept    (accept),
        .reject    (reject),
        .len_bad   (len_bad)
    );

    // Status pulses for the completion seen in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_tag   <= '0;
            done_dest  <= '0;
            err_unexp  <= 1'b0;
            err_len    <= 1'b0;
        end else begin
            done_valid <= accept;
            err_unexp  <= reject;
            err_len    <= len_bad;
            if (accept) begin
                done_tag  <= cpl_tag;
                done_dest <= look_entry.dest;
            end
        end
    end

    // Outstanding counter, moved by grants and retirements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_count <= '0;
        end else if (alloc_fire && !accept) begin
            busy_count <= busy_count + 1'b1;
        end else if (!alloc_fire && accept) begin
            busy_count <= busy_count - 1'b1;
        end
    end
endmodule

// File: rtl/tag_tracker_chk.sv
// Property checker for split_tag_tracker, attached by bind below.
// Assumes: busy is the tracker's internal outstanding mask.
module tag_tracker_chk
    import tag_tracker_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [TAG_W-1:0] req_tag,
    input logic [CNT_W-1:0] busy_count,
    input logic             done_valid,
    input logic [TAG_W-1:0] done_tag,
    input logic             err_unexp,
    input logic             err_len,
    input mask_t            busy
);
    p_alloc_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy[$past(req_tag)]);

    p_grant_was_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> !busy[req_tag]);

    p_stall_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_count == CNT_W'(NUM_TAGS)) |-> !req_ready);

    p_retired_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !busy[done_tag]);

    p_unexp_not_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_unexp |-> !done_valid);

    p_len_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_len |-> done_valid);

    p_count_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_count == CNT_W'($countones(busy)));
endmodule

bind split_tag_tracker tag_tracker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_tag    (req_tag),
    .busy_count (busy_count),
    .done_valid (done_valid),
    .done_tag   (done_tag),
    .err_unexp  (err_unexp),
    .err_len    (err_len),
    .busy       (busy_mask)
);

// File: tb/split_tag_tracker_tb.sv
// Bench for split_tag_tracker: a behavioural model of the tag set is
// advanced with every stimulus cycle and compared with the ports on each clock.
module split_tag_tracker_tb;
    import tag_tracker_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic  rst_n;
    logic  req_valid;
    rid_t  req_rid;
    bc_t   req_bytes;
    dest_t req_dest;
    logic  req_ready;
    tag_t  req_tag;
    logic  cpl_valid;
    rid_t  cpl_rid;
    tag_t  cpl_tag;
    bc_t   cpl_bytes;
    logic  done_valid;
    tag_t  done_tag;
    dest_t done_dest;
    logic  err_unexp;
    logic  err_len;
    logic [CNT_W-1:0] busy_count;

    split_tag_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_rid(req_rid), .req_bytes(req_bytes),
        .req_dest(req_dest), .req_ready(req_ready), .req_tag(req_tag),
        .cpl_valid(cpl_valid), .cpl_rid(cpl_rid), .cpl_tag(cpl_tag),
        .cpl_bytes(cpl_bytes), .done_valid(done_valid), .done_tag(done_tag),
        .done_dest(done_dest), .err_unexp(err_unexp), .err_len(err_len),
        .busy_count(busy_count)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    bit    m_busy [NUM_TAGS];
    rid_t  m_rid  [NUM_TAGS];
    bc_t   m_bc   [NUM_TAGS];
    dest_t m_dest [NUM_TAGS];
    int    e_count = 0;
    bit    e_done = 0, e_unexp = 0, e_len = 0;
    int    e_tag = 0, e_dst = 0;
    string e_lbl = "R1";

    rid_t RA, RB;

    task automatic chk(input string r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    function automatic int m_lowest();
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (!m_busy[i]) return i;
        end
        return -1;
    endfunction

    // One cycle: check last edge's results, drive new inputs, check grant, advance model.
    task automatic step(input string lbl, input bit rv, input rid_t rr, input int rb,
                        input int rd, input bit cv, input rid_t cr, input int ct,
                        input int cb);
        int lw;
        @(negedge clk);
        chk(e_lbl, "done_valid", int'(done_valid), int'(e_done));
        if (e_done) begin
            chk(e_lbl, "done_tag", int'(done_tag), e_tag);
            chk(e_lbl, "done_dest", int'(done_dest), e_dst);
        end
        chk(e_lbl, "err_unexp", int'(err_unexp), int'(e_unexp));
        chk(e_lbl, "err_len", int'(err_len), int'(e_len));
        chk("R10", "busy_count", int'(busy_count), e_count);
        req_valid = rv; req_rid = rr; req_bytes = bc_t'(rb); req_dest = dest_t'(rd);
        cpl_valid = cv; cpl_rid = cr; cpl_tag = tag_t'(ct); cpl_bytes = bc_t'(cb);
        #1;
        lw = m_lowest();
        chk(lbl, "req_ready", int'(req_ready), int'(lw >= 0));
        if (lw >= 0) chk(lbl, "req_tag", int'(req_tag), lw);
        e_lbl = lbl; e_done = 0; e_unexp = 0; e_len = 0;
        if (cv) begin
            if (m_busy[ct] && m_rid[ct] == cr) begin
                e_done = 1; e_tag = ct; e_dst = int'(m_dest[ct]);
                e_len = (m_bc[ct] != bc_t'(cb));
                m_busy[ct] = 0;
                e_count--;
            end else begin
                e_unexp = 1;
            end
        end
        if (rv && lw >= 0) begin
            m_busy[lw] = 1; m_rid[lw] = rr; m_bc[lw] = bc_t'(rb); m_dest[lw] = dest_t'(rd);
            e_count++;
        end
    endtask

    task automatic idle(input string lbl);
        step(lbl, 0, '0, 0, 0, 0, '0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        finish_run();
    end

    initial begin
        RA = make_rid(8'h12, 5'd3, 3'd1);
        RB = make_rid(8'h12, 5'd3, 3'd2);
        for (int i = 0; i < NUM_TAGS; i++) begin
            m_busy[i] = 0; m_rid[i] = '0; m_bc[i] = '0; m_dest[i] = '0;
        end
        rst_n = 0;
        req_valid = 0; req_rid = '0; req_bytes = '0; req_dest = '0;
        cpl_valid = 0; cpl_rid = '0; cpl_tag = '0; cpl_bytes = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "req_ready", int'(req_ready), 1);
        chk("R1", "req_tag", int'(req_tag), 0);
        chk("R1", "busy_count", int'(busy_count), 0);
        chk("R1", "done_valid", int'(done_valid), 0);
        chk("R1", "err_unexp", int'(err_unexp), 0);
        chk("R1", "err_len", int'(err_len), 0);
        rst_n = 1;

        // R2: three grants, lowest free tag first
        for (int i = 0; i < 3; i++) step("R2", 1, RA, 100 + i, 16 + i, 0, '0, 0, 0);
        // R4: correct completion of tag 1
        step("R4", 0, '0, 0, 0, 1, RA, 1, 101);
        // R8: tag 1 is offered again once retired
        step("R8", 1, RA, 200, 32, 0, '0, 0, 0);
        // R5: completion for an idle tag
        step("R5", 0, '0, 0, 0, 1, RA, 9, 5);
        // R6: identity mismatch on live tag 0, then correct identity still works
        step("R6", 0, '0, 0, 0, 1, RB, 0, 100);
        // R7: wrong byte count still retires tag 0
        step("R7", 0, '0, 0, 0, 1, RA, 0, 55);
        idle("R7");
        // R3: fill the table and keep offering while full
        for (int i = 0; i < 36; i++) step("R3", 1, RA, 300 + i, i, 0, '0, 0, 0);
        // R9: request and completion together at a full table
        step("R9", 1, RA, 400, 77, 1, RA, 7, int'(m_bc[7]));
        // R9: freed tag 7 granted one cycle later
        step("R9", 1, RA, 401, 78, 0, '0, 0, 0);
        // R9: free tag 3, then complete it while it is being granted again
        step("R9", 0, '0, 0, 0, 1, RA, 3, int'(m_bc[3]));
        step("R9", 1, RB, 402, 79, 1, RA, 3, 402);
        // R4 / R9: drain everything, granting on some cycles
        for (int t = 0; t < NUM_TAGS; t++) begin
            if (t % 3 == 0)
                step("R9", 1, RB, 500 + t, t, 1, m_rid[t], t, int'(m_bc[t]));
            else
                step("R4", 0, '0, 0, 0, 1, m_rid[t], t, int'(m_bc[t]));
        end
        for (int t = 0; t < NUM_TAGS; t++) begin
            if (m_busy[t]) step("R4", 0, '0, 0, 0, 1, m_rid[t], t, int'(m_bc[t]));
        end
        idle("R10");
        idle("R10");
        finish_run();
    end
endmodule